// File: doc/BRIEF.md
# Serial Command Shift Interface

This block is the serial front end of a command-driven peripheral. It runs entirely in the system clock domain. The serial clock, serial data and the active-low chip-select/load line all arrive asynchronously. They are passed through a synchronizer and then edge-detected. While chip select is low, each rising edge of the serial clock shifts one data bit into a 32-bit shift register. The register's top bit is sent back out on the serial data output at each falling edge. This gives echo readback, and it lets several parts be chained with their serial lines in series.

When chip select goes high again, the block checks how many rising edges the frame held. A frame of exactly 24 or exactly 32 bits is accepted. The last 24 bits received are split into a 4-bit command, a 4-bit channel address and a 16-bit data field, and a one-cycle valid strobe is raised. A frame of any other length is dropped. The block does not interpret the command and stores no registers of its own.

The controller has three states. `S_IDLE` waits for a falling edge on chip select; the transition *open* clears the shift register, the bit counter and the serial output. `S_SHIFT` collects bits; the transition *close* fires on a rising edge of chip select. `S_COMMIT` lasts one cycle and checks the frame length; the transition *finish* returns to `S_IDLE`. Serial clock edges are acted on only in `S_SHIFT`.

Top module: `cmd_shift_port`

## Requirements
- R1: After reset, `valid_o`, `sdo_oe_o` and `sdo_o` are 0, and `cmd_o`, `addr_o` and `data_o` are all zero.
- R2: `sdo_oe_o` is 1 while chip select is held low, after the synchronizer delay. It is 0 while chip select is high, including the cycle in which `valid_o` is 1.
- R3: Edges on `sck_i` while `csn_i` is high change nothing: no strobe, no change of the fields, and `sdo_oe_o` stays 0.
- R4: A 24-bit frame is sent MSB first and is sampled on rising `sck_i` edges. Bits 23..20 go to `cmd_o`, bits 19..16 to `addr_o` and bits 15..0 to `data_o`.
- R5: In a 32-bit frame the first 8 bits received are ignored. The remaining 24 bits are decoded exactly as in R4.
- R6: A frame whose count of rising edges is neither 24 nor 32 produces no strobe, and the three fields keep their previous values. Counts above 32 saturate and are therefore rejected.
- R7: `valid_o` is raised only after chip select returns high, never while the frame is still open. It lasts exactly one system clock cycle per accepted frame.
- R8: The bit sampled at rising edge k appears on `sdo_o` at the falling edge that follows rising edge k+31, so it is delayed by 32 rising edges. `sdo_o` does not change on rising edges.
- R9: At the start of each frame the shift register is cleared. Before rising edge 32 of a frame, `sdo_o` therefore shows 0 after each falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| csn_i | input | 1 | Active-low chip select / load, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous, slower than clk |
| sdi_i | input | 1 | Serial data in, sampled on rising sck_i |
| cmd_o | output | 4 | Command field of the last accepted frame |
| addr_o | output | 4 | Channel address field of the last accepted frame |
| data_o | output | 16 | Data field of the last accepted frame |
| valid_o | output | 1 | One-cycle strobe for an accepted frame |
| sdo_o | output | 1 | Serial data out (echo / chain) |
| sdo_oe_o | output | 1 | Output enable for sdo_o; 0 means high impedance |

## Verification
The bound checker checks these rules on every cycle:
- the strobe is never wider than one cycle, and it only appears when the bit count is 24 or 32;
- the output enable is off whenever the strobe is up;
- the shift register is frozen outside `S_SHIFT`, except for the clear on the *open* transition;
- the serial output changes only on a serial-clock falling edge or a frame start.

Only the directed scenarios can show the rest: the decoded field values for 24- and 32-bit frames, that rejected lengths leave the fields untouched, that idle serial-clock activity is ignored, and the exact 32-edge echo delay with zeros ahead of it.

// File: rtl/cmd_shift_pkg.sv
package cmd_shift_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SHIFT  = 2'd1,
        S_COMMIT = 2'd2
    } frame_state_e;
endpackage

// File: rtl/cmd_shift_sync.sv
// Multi-stage synchronizer for a vector of asynchronous single-bit inputs.
module cmd_shift_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[s] <= RST_VAL;
                end else begin
                    if (s == 0) pipe[s] <= d;
                    else        pipe[s] <= pipe[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/cmd_shift_edge.sv
// Rising/falling edge detection on already-synchronized levels.
module cmd_shift_edge #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/cmd_shift_core.sv
// Shift register, saturating bit counter and falling-edge serial output.
module cmd_shift_core #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              en,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi,
    output logic [WORD_W-1:0] shreg,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              sdo
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            sdo     <= 1'b0;
        end else if (clear) begin
            shreg   <= '0;
            bit_cnt <= '0;
            sdo     <= 1'b0;
        end else if (en) begin
            if (sck_rise) begin
                shreg <= {shreg[WORD_W-2:0], sdi};
                if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
            end
            if (sck_fall) sdo <= shreg[WORD_W-1];
        end
    end
endmodule

// File: rtl/cmd_shift_port.sv
// Serial command shift interface: frame controller and field outputs.
module cmd_shift_port
    import cmd_shift_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int SHORT_W     = 24,
    parameter int CMD_W       = 4,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              sdo_o,
    output logic              sdo_oe_o
);
    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam int FIELD_W = CMD_W + ADDR_W + DATA_W;

    // synchronized inputs: {csn, sck, sdi}
    logic [2:0] raw_in, syn_in;
    logic [1:0] lvl, rise, fall;
    logic       csn_s, sck_s, sdi_s;
    logic       csn_rise, csn_fall, sck_rise, sck_fall;

    assign raw_in = {csn_i, sck_i, sdi_i};

    cmd_shift_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
    );

    assign {csn_s, sck_s, sdi_s} = syn_in;
    assign lvl = {csn_s, sck_s};

    cmd_shift_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall)
    );

    assign {csn_rise, sck_rise} = rise;
    assign {csn_fall, sck_fall} = fall;

    frame_state_e        state_q, state_n;
    logic                clear_sr;
    logic [WORD_W-1:0]   shreg;
    logic [CNT_W-1:0]    bit_cnt;
    logic                len_ok;

    cmd_shift_core #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .clear(clear_sr),
        .en(state_q == S_SHIFT),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi(sdi_s),
        .shreg(shreg), .bit_cnt(bit_cnt), .sdo(sdo_o)
    );

    assign len_ok = (bit_cnt == CNT_W'(SHORT_W)) || (bit_cnt == CNT_W'(WORD_W));

    // next-state logic
    always_comb begin
        state_n  = state_q;
        clear_sr = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (csn_fall) begin           // open
                    state_n  = S_SHIFT;
                    clear_sr = 1'b1;
                end
            end
            S_SHIFT: begin
                if (csn_rise) state_n = S_COMMIT;   // close
            end
            S_COMMIT: state_n = S_IDLE;             // finish
            default:  state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            sdo_oe_o <= 1'b0;
            cmd_o    <= '0;
            addr_o   <= '0;
            data_o   <= '0;
        end else begin
            valid_o  <= 1'b0;
            sdo_oe_o <= (state_n == S_SHIFT);
            if (state_q == S_COMMIT && len_ok) begin
                valid_o <= 1'b1;
                {cmd_o, addr_o, data_o} <= shreg[FIELD_W-1:0];
            end
        end
    end
endmodule

// File: rtl/cmd_shift_chk.sv
module cmd_shift_chk
    import cmd_shift_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int SHORT_W = 24,
    parameter int CNT_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input frame_state_e      state,
    input logic              csn_fall,
    input logic              sck_fall,
    input logic [WORD_W-1:0] shreg,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              valid_o,
    input logic              sdo_o,
    input logic              sdo_oe_o
);
    a_r7_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r6_len_gate: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (bit_cnt == CNT_W'(SHORT_W) || bit_cnt == CNT_W'(WORD_W)));

    a_r2_no_oe_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !sdo_oe_o);

    a_r3_frozen_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_SHIFT && !csn_fall) |=> $stable(shreg));

    a_r8_sdo_on_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !csn_fall) |=> $stable(sdo_o));
endmodule

bind cmd_shift_port cmd_shift_chk #(
    .WORD_W(WORD_W), .SHORT_W(SHORT_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q),
    .csn_fall(csn_fall), .sck_fall(sck_fall),
    .shreg(shreg), .bit_cnt(bit_cnt),
    .valid_o(valid_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
);

// File: tb/cmd_shift_port_bench.sv
`timescale 1ns/1ps
module cmd_shift_port_bench;
    localparam int HP = 8;   // serial half period in system clocks
    localparam int ST = 6;   // settle time after a serial edge

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic [3:0]  cmd, addr;
    logic [15:0] data;
    logic valid, sdo, sdo_oe;

    always #2.5 clk = ~clk;   // 200 MHz

    cmd_shift_port u_cmd_shift_port (
        .clk(clk), .rst_n(rst_n), .csn_i(csn), .sck_i(sck), .sdi_i(sdi),
        .cmd_o(cmd), .addr_o(addr), .data_o(data),
        .valid_o(valid), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    int n_chk = 0, n_bad = 0;
    int v_cycles = 0, v_pulses = 0;
    logic v_prev = 1'b0;
    bit done = 1'b0;

    always @(negedge clk) begin
        if (valid) begin
            v_cycles++;
            if (!v_prev) v_pulses++;
        end
        v_prev <= valid;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends n bits (MSB first from bits[n-1]); optionally checks the echo.
    task automatic send_frame(input logic [63:0] bits, input int n, input bit echo);
        int vc0;
        logic exp_sdo;
        vc0 = v_cycles;
        exp_sdo = 1'b0;
        @(negedge clk); csn = 1'b0;
        wclk(HP);
        chk(sdo_oe === 1'b1, "R2 oe in frame", 32'(sdo_oe), 1);
        for (int i = 0; i < n; i++) begin
            sdi = bits[n-1-i];
            wclk(HP - ST);
            wclk(ST);
            sck = 1'b1;
            wclk(ST);
            if (echo) chk(sdo === exp_sdo, "R8 no change on rise", 32'(sdo), 32'(exp_sdo));
            wclk(HP - ST);
            sck = 1'b0;
            wclk(ST);
            if (echo) begin
                exp_sdo = (i + 1 >= 32) ? bits[n - (i + 1) + 31] : 1'b0;
                if (i + 1 < 32) chk(sdo === exp_sdo, "R9 zero before 32", 32'(sdo), 32'(exp_sdo));
                else            chk(sdo === exp_sdo, "R8 echo delay", 32'(sdo), 32'(exp_sdo));
            end
            wclk(HP - ST);
        end
        chk(v_cycles == vc0, "R7 no strobe in frame", v_cycles, vc0);
        csn = 1'b1;
        wclk(12);
        chk(sdo_oe === 1'b0, "R2 oe after frame", 32'(sdo_oe), 0);
    endtask

    task automatic t_reset();
        chk(valid === 1'b0 && sdo_oe === 1'b0 && sdo === 1'b0, "R1 reset ctrl",
            {29'd0, valid, sdo_oe, sdo}, 0);
        chk({cmd, addr, data} === 24'd0, "R1 reset fields", {8'd0, cmd, addr, data}, 0);
    endtask

    task automatic t_idle_sck();
        int p0;
        p0 = v_pulses;
        for (int i = 0; i < 10; i++) begin
            sdi = i[0];
            wclk(HP); sck = 1'b1;
            wclk(ST);
            chk(sdo_oe === 1'b0, "R3 oe idle", 32'(sdo_oe), 0);
            wclk(HP - ST); sck = 1'b0;
        end
        wclk(12);
        chk(v_pulses == p0, "R3 no strobe idle", v_pulses, p0);
        chk({cmd, addr, data} === 24'hA51234, "R3 fields kept", {8'd0, cmd, addr, data}, 32'hA51234);
    endtask

    task automatic t_short();
        int p0;
        p0 = v_pulses;
        send_frame(64'hA51234, 24, 1'b0);
        chk(v_pulses == p0 + 1, "R4 strobe", v_pulses, p0 + 1);
        chk(cmd === 4'hA, "R4 cmd", 32'(cmd), 32'hA);
        chk(addr === 4'h5, "R4 addr", 32'(addr), 32'h5);
        chk(data === 16'h1234, "R4 data", 32'(data), 32'h1234);
        chk(v_cycles == v_pulses, "R7 one cycle", v_cycles, v_pulses);
    endtask

    task automatic t_long();
        int p0;
        p0 = v_pulses;
        send_frame(64'hFF3CBEEF, 32, 1'b0);
        chk(v_pulses == p0 + 1, "R5 strobe", v_pulses, p0 + 1);
        chk({cmd, addr, data} === 24'h3CBEEF, "R5 fields", {8'd0, cmd, addr, data}, 32'h3CBEEF);
        chk(v_cycles == v_pulses, "R7 one cycle long", v_cycles, v_pulses);
    endtask

    task automatic t_bad_len();
        int p0;
        p0 = v_pulses;
        send_frame(64'h12345678, 31, 1'b0);
        chk(v_pulses == p0, "R6 31 bits", v_pulses, p0);
        send_frame(64'h1_2345_6789, 33, 1'b0);
        chk(v_pulses == p0, "R6 33 bits", v_pulses, p0);
        send_frame(64'h9876, 20, 1'b0);
        chk(v_pulses == p0, "R6 20 bits", v_pulses, p0);
        chk({cmd, addr, data} === 24'h3CBEEF, "R6 fields kept", {8'd0, cmd, addr, data}, 32'h3CBEEF);
    endtask

    task automatic t_echo();
        int p0;
        p0 = v_pulses;
        send_frame(64'hC3A5_0F96_5AF0_1E87, 64, 1'b1);
        chk(v_pulses == p0, "R6 64 bits rejected", v_pulses, p0);
    endtask

    initial begin
        wclk(5);
        t_reset();
        rst_n = 1'b1;
        wclk(5);
        t_short();
        t_idle_sck();
        t_long();
        t_bad_len();
        t_echo();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule